// File: doc/BRIEF.md
# Multi-Lane Serial-to-Parallel Event Deframer

This block takes the 16-bit input bus of one front-end board and splits it into eight independent two-bit ADC lanes. Each lane sends its words most-significant pair first, two bits per clock. A lane stays idle and searches for a start-of-event marker. Once it finds the marker it rebuilds a 16-bit word every eight clocks. The block labels each word by its position in the event: header, read address, data, or the closing end word.

Each lane raises a one-cycle valid strobe when it completes a word. The rebuilt word and its type label are presented alongside the strobe. The block checks even parity on header, address and data words. The end word is exempt from that check, and the marker is never passed on at all. A parity failure raises a one-cycle per-lane error bit, together with a summary flag and the index of the lowest lane that failed in that cycle. After the end word the lane goes back to searching. The lanes share one clock but find their markers independently, so their events may be offset from one another.

Top module: `deframer_top`

## Requirements
- R1: While reset is asserted, and until a lane has completed a word after reset, every valid strobe and parity-error bit is low and every word output is zero.
- R2: Lane l takes bus bits [2l+1:2l]. Its first pair after the marker becomes word bits [15:14] and its eighth pair becomes bits [1:0].
- R3: A lane locks only after its last eight pairs equal the START_MARK parameter (default 16'hF0A5). It produces no output before that.
- R4: After the marker, a word completes every eight clocks. Its valid strobe is high for exactly the one cycle after the clock edge that sampled the eighth pair.
- R5: Words are tagged in order. The tag codes are 0 for header, 1 for read address, 2 for data and 3 for end. An event carries HDR_WORDS headers (default 2), ADDR_WORDS addresses (default 1), DATA_WORDS data words (default 4) and then one end word.
- R6: After the end word the lane searches for a new marker again. It produces no output until that marker has been received.
- R7: A header, address or data word with an odd number of ones raises that lane's parity-error bit in the same cycle as its valid strobe. The error bit is never high without the strobe.
- R8: An end word never raises a parity error, whatever its contents. A marker value arriving inside an event is treated as ordinary data.
- R9: The any-error flag equals the OR of all per-lane error bits. When the flag is set, the index output gives the lowest-numbered lane with an error.
- R10: Each lane finds its own marker, so lanes that start at different clock cycles each produce correctly framed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_i | input | 16 | Serial input, two bits per lane |
| word_o | output | 128 | Rebuilt word per lane, lane l at bits [16l+15:16l] |
| valid_o | output | 8 | One-cycle word-complete strobe per lane |
| tag_o | output | 16 | Word type per lane, lane l at bits [2l+1:2l] |
| perr_o | output | 8 | One-cycle parity-error bit per lane |
| perr_any_o | output | 1 | Some lane has a parity error this cycle |
| perr_idx_o | output | 3 | Lowest lane with a parity error |

## Verification
The assertions check the following on every cycle:
- the strobe lasts a single cycle;
- the error bit appears only with a strobe and matches the parity of the word for non-end tags;
- end words never flag an error;
- the word output holds between strobes;
- the any-error flag and the index agree with the per-lane bits.

Some behaviour only the bench scenarios can show:
- the marker search, including noise before the marker and a marker value inside an event;
- the bit order within a word;
- the eight-clock spacing and the tag sequence;
- the return to searching after the end word;
- independent lane offsets.

The bench shows these by predicting the exact cycle and contents of every word.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [1:0] {
    TAG_HDR  = 2'd0,
    TAG_RADD = 2'd1,
    TAG_DATA = 2'd2,
    TAG_END  = 2'd3
  } word_tag_e;

  typedef enum logic {
    LS_HUNT = 1'b0,
    LS_LOCK = 1'b1
  } lane_state_e;

endpackage

// File: rtl/deframer_lane.sv
module deframer_lane
  import deframer_pkg::*;
#(
  parameter int unsigned        WORD_W     = 16,
  parameter int unsigned        LANE_W     = 2,
  parameter logic [WORD_W-1:0]  START_MARK = 16'hF0A5,
  parameter int unsigned        HDR_WORDS  = 2,
  parameter int unsigned        ADDR_WORDS = 1,
  parameter int unsigned        DATA_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] pair_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [1:0]        tag_o,
  output logic              perr_o
);

  localparam int unsigned PAIRS = WORD_W / LANE_W;
  localparam int unsigned PCW   = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int unsigned FRAME = HDR_WORDS + ADDR_WORDS + DATA_WORDS + 1;
  localparam int unsigned WCW   = $clog2(FRAME + 1);
  localparam logic [PCW-1:0] LAST_P   = PCW'(PAIRS - 1);
  localparam logic [WCW-1:0] HDR_LIM  = WCW'(HDR_WORDS);
  localparam logic [WCW-1:0] ADDR_LIM = WCW'(HDR_WORDS + ADDR_WORDS);
  localparam logic [WCW-1:0] DATA_LIM = WCW'(HDR_WORDS + ADDR_WORDS + DATA_WORDS);

  lane_state_e       state_q, state_n;
  logic [WORD_W-1:0] sr_q, sr_d, sr_shift;
  logic [PCW-1:0]    pcnt_q, pcnt_n;
  logic [WCW-1:0]    widx_q, widx_n;
  logic              valid_q, valid_n;
  logic              perr_q, perr_n;
  logic [WORD_W-1:0] word_q;
  word_tag_e         tag_q, tag_cur;
  logic              word_en;

  // position in the event selects the type label
  always_comb begin
    if (widx_q < HDR_LIM)       tag_cur = TAG_HDR;
    else if (widx_q < ADDR_LIM) tag_cur = TAG_RADD;
    else if (widx_q < DATA_LIM) tag_cur = TAG_DATA;
    else                        tag_cur = TAG_END;
  end

  always_comb begin
    sr_shift = {sr_q[WORD_W-LANE_W-1:0], pair_i};
    state_n  = state_q;
    sr_d     = sr_shift;
    pcnt_n   = pcnt_q;
    widx_n   = widx_q;
    valid_n  = 1'b0;
    perr_n   = 1'b0;
    word_en  = 1'b0;
    unique case (state_q)
      LS_HUNT: begin
        if (sr_shift == START_MARK) begin
          state_n = LS_LOCK;
          pcnt_n  = '0;
          widx_n  = '0;
        end
      end
      LS_LOCK: begin
        if (pcnt_q == LAST_P) begin
          pcnt_n  = '0;
          valid_n = 1'b1;
          word_en = 1'b1;
          perr_n  = (^sr_shift) && (tag_cur != TAG_END);
          if (tag_cur == TAG_END) begin
            state_n = LS_HUNT;
            sr_d    = '0;
            widx_n  = '0;
          end else begin
            widx_n = widx_q + 1'b1;
          end
        end else begin
          pcnt_n = pcnt_q + 1'b1;
        end
      end
      default: state_n = LS_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_HUNT;
      sr_q    <= '0;
      pcnt_q  <= '0;
      widx_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      word_q  <= '0;
      tag_q   <= TAG_HDR;
    end else begin
      state_q <= state_n;
      sr_q    <= sr_d;
      pcnt_q  <= pcnt_n;
      widx_q  <= widx_n;
      valid_q <= valid_n;
      perr_q  <= perr_n;
      if (word_en) begin
        word_q <= sr_shift;
        tag_q  <= tag_cur;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign perr_o  = perr_q;

endmodule

// File: rtl/deframer_perr_enc.sv
module deframer_perr_enc #(
  parameter int unsigned LANES = 8,
  localparam int unsigned IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] perr_i,
  output logic             any_o,
  output logic [IDXW-1:0]  idx_o
);

  always_comb begin
    any_o = |perr_i;
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (perr_i[i]) idx_o = IDXW'(i);
    end
  end

endmodule

// File: rtl/deframer_top.sv
module deframer_top #(
  parameter int unsigned        LANES      = 8,
  parameter int unsigned        LANE_W     = 2,
  parameter int unsigned        WORD_W     = 16,
  parameter logic [WORD_W-1:0]  START_MARK = 16'hF0A5,
  parameter int unsigned        HDR_WORDS  = 2,
  parameter int unsigned        ADDR_WORDS = 1,
  parameter int unsigned        DATA_WORDS = 4,
  localparam int unsigned       IDXW       = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] bus_i,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic [LANES-1:0]        valid_o,
  output logic [LANES*2-1:0]      tag_o,
  output logic [LANES-1:0]        perr_o,
  output logic                    perr_any_o,
  output logic [IDXW-1:0]         perr_idx_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    deframer_lane #(
      .WORD_W    (WORD_W),
      .LANE_W    (LANE_W),
      .START_MARK(START_MARK),
      .HDR_WORDS (HDR_WORDS),
      .ADDR_WORDS(ADDR_WORDS),
      .DATA_WORDS(DATA_WORDS)
    ) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pair_i (bus_i[g*LANE_W +: LANE_W]),
      .word_o (word_o[g*WORD_W +: WORD_W]),
      .valid_o(valid_o[g]),
      .tag_o  (tag_o[g*2 +: 2]),
      .perr_o (perr_o[g])
    );
  end

  deframer_perr_enc #(.LANES(LANES)) enc_i (
    .perr_i(perr_o),
    .any_o (perr_any_o),
    .idx_o (perr_idx_o)
  );

endmodule

// File: rtl/deframer_chk.sv
module deframer_chk #(
  parameter int unsigned  LANES  = 8,
  parameter int unsigned  LANE_W = 2,
  parameter int unsigned  WORD_W = 16,
  localparam int unsigned IDXW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*LANE_W-1:0] bus_i,
  input logic [LANES*WORD_W-1:0] word_o,
  input logic [LANES-1:0]        valid_o,
  input logic [LANES*2-1:0]      tag_o,
  input logic [LANES-1:0]        perr_o,
  input logic                    perr_any_o,
  input logic [IDXW-1:0]         perr_idx_o
);

  logic [LANES-1:0] below_idx;
  assign below_idx = (LANES'(1) << perr_idx_o) - LANES'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o[g] |=> !valid_o[g]);

    assert_perr_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o[g] |-> valid_o[g]);

    assert_perr_is_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[g] && tag_o[g*2 +: 2] != 2'd3) |-> (perr_o[g] == ^word_o[g*WORD_W +: WORD_W]));

    assert_end_no_perr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[g] && tag_o[g*2 +: 2] == 2'd3) |-> !perr_o[g]);

    assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o[g] |-> $stable(word_o[g*WORD_W +: WORD_W]));
  end

  assert_any_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_any_o == (perr_o != '0));

  assert_lowest_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_any_o |-> (perr_o[perr_idx_o] && ((perr_o & below_idx) == '0)));

endmodule

bind deframer_top deframer_chk #(
  .LANES (LANES),
  .LANE_W(LANE_W),
  .WORD_W(WORD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_i     (bus_i),
  .word_o    (word_o),
  .valid_o   (valid_o),
  .tag_o     (tag_o),
  .perr_o    (perr_o),
  .perr_any_o(perr_any_o),
  .perr_idx_o(perr_idx_o)
);

// File: tb/deframer_top_tb_top.sv
module deframer_top_tb_top;

  localparam int NL    = 8;
  localparam int NS    = 90;
  localparam int NSCN  = 16;
  localparam int NWORD = 8;
  localparam logic [15:0] MARK = 16'hF0A5;

  logic          clk;
  logic          rst_n;
  logic [15:0]   bus_i;
  logic [127:0]  word_o;
  logic [7:0]    valid_o;
  logic [15:0]   tag_o;
  logic [7:0]    perr_o;
  logic          perr_any_o;
  logic [2:0]    perr_idx_o;

  int total;
  int bad;

  logic [1:0]  pr [NL][NS+1];
  logic        ev [NL][NS+1];
  logic [15:0] ew [NL][NS+1];
  logic [1:0]  et [NL][NS+1];
  logic        ep [NL][NS+1];

  deframer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .word_o(word_o),
    .valid_o(valid_o), .tag_o(tag_o), .perr_o(perr_o),
    .perr_any_o(perr_any_o), .perr_idx_o(perr_idx_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] tag_of(int k);
    if (k < 2) return 2'd0;
    if (k < 3) return 2'd1;
    if (k < 7) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [15:0] word_of(int s, int l, int k);
    if (l == (s % NL) && k == 4) return MARK;  // marker value inside event, R8
    return 16'(s * 16'h1357 + l * 16'h0B1D + k * 16'h2469 + s * l * k);
  endfunction

  task automatic build(int s);
    for (int l = 0; l < NL; l++) begin
      int o;
      o = (s * 3 + l * 5) % 11;  // distinct lane offsets, R10
      for (int c = 0; c <= NS; c++) begin
        pr[l][c] = 2'd0; ev[l][c] = 1'b0; ew[l][c] = '0; et[l][c] = '0; ep[l][c] = 1'b0;
      end
      if (s % 2 == 1) begin
        for (int c = 0; c < o; c++) begin  // aligned 0F0F noise before marker, R3
          int d, ix;
          d  = o - c;
          ix = (8 - (d % 8)) % 8;
          pr[l][c] = 2'((16'h0F0F >> (14 - 2 * ix)) & 16'h3);
        end
      end
      for (int p = 0; p < 8; p++) pr[l][o + p] = 2'((MARK >> (14 - 2 * p)) & 16'h3);
      for (int k = 0; k < NWORD; k++) begin
        logic [15:0] w;
        int sl;
        w = word_of(s, l, k);
        for (int p = 0; p < 8; p++) pr[l][o + 8 + 8 * k + p] = 2'((w >> (14 - 2 * p)) & 16'h3);
        sl = o + 15 + 8 * k;
        ev[l][sl] = 1'b1;
        ew[l][sl] = w;
        et[l][sl] = tag_of(k);
        ep[l][sl] = (^w) && (tag_of(k) != 2'd3);
      end
    end
  endtask

  task automatic check_slot(int c);
    logic [7:0] pv;
    int lo;
    pv = '0;
    lo = 0;
    for (int l = 0; l < NL; l++) begin
      total++;
      if (valid_o[l] !== ev[l][c]) begin
        bad++;
        $display("FAIL R4 (R3,R6) lane %0d slot %0d valid got %0b exp %0b", l, c, valid_o[l], ev[l][c]);
      end
      if (ev[l][c]) begin
        total++;
        if (word_o[l*16 +: 16] !== ew[l][c]) begin
          bad++;
          $display("FAIL R2 lane %0d slot %0d word got %h exp %h", l, c, word_o[l*16 +: 16], ew[l][c]);
        end
        total++;
        if (tag_o[l*2 +: 2] !== et[l][c]) begin
          bad++;
          $display("FAIL R5 lane %0d slot %0d tag got %0d exp %0d", l, c, tag_o[l*2 +: 2], et[l][c]);
        end
      end
      total++;
      if (perr_o[l] !== ep[l][c]) begin
        bad++;
        $display("FAIL R7/R8 lane %0d slot %0d perr got %0b exp %0b", l, c, perr_o[l], ep[l][c]);
      end
      pv[l] = ep[l][c];
    end
    for (int l = NL - 1; l >= 0; l--) if (pv[l]) lo = l;
    total++;
    if (perr_any_o !== (pv != 0) || ((pv != 0) && perr_idx_o !== 3'(lo))) begin
      bad++;
      $display("FAIL R9 slot %0d any/idx got %0b/%0d exp %0b/%0d", c, perr_any_o, perr_idx_o, (pv != 0), lo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    bus_i = '0;
    repeat (3) @(negedge clk);
    total++;  // R1 during reset
    if (valid_o !== '0 || perr_o !== '0 || word_o !== '0) begin
      bad++;
      $display("FAIL R1 in reset valid %h perr %h exp 0", valid_o, perr_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    total++;  // R1 after release, idle bus
    if (valid_o !== '0 || perr_any_o !== 1'b0 || word_o !== '0) begin
      bad++;
      $display("FAIL R1 after reset valid %h any %0b exp 0", valid_o, perr_any_o);
    end
    for (int s = 0; s < NSCN; s++) begin
      build(s);
      for (int c = 0; c <= NS; c++) begin
        @(negedge clk);
        if (c > 0) check_slot(c - 1);  // R6: idle slots after end stay silent
        for (int l = 0; l < NL; l++) bus_i[l*2 +: 2] = (c < NS) ? pr[l][c] : 2'd0;
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule